// File: doc/BRIEF.md
# Packet FIFO with Mark, Commit and Restore

This block stores 32-bit words in a dual-port memory and hands them to a reader in order. Unlike an ordinary FIFO, the writer works on whole packets. It can set a mark at the start of a packet. It then either commits the packet, which makes it visible to the reader, or restores to the mark, which discards everything written since. The packet can then be written again. Words written but not committed take up space, but the reader cannot see them.

Both data sides are valid/ready streams. A word moves on a cycle where valid and ready are both high. The writer holds `in_valid` and `in_data` until `in_ready` is seen. `in_ready` is low when the memory is full, and also in any cycle where `rewind` is asserted. The reader sees `out_valid` only while at least one committed word is unread. `out_data` is valid whenever `out_valid` is high.

A small register port gives access to the FIFO state:
- Offset 0 returns a fixed identification word when read. Writing the key value 0x0000000A to offset 0 empties the FIFO.
- Offset 4 returns a count and three status flags. The `KIND` parameter picks how they read. A read-type instance (0) reports what the reader has available. A write-type instance (1) reports the space the writer has left.

If one packet grows to the full capacity without being committed, the memory is full and empty at the same time. The block flags this as a deadlock and raises a sticky error interrupt.

Top module: `pkt_fifo_mr`

## Requirements
- R1: After reset, a read-type instance reads status 0x80000000 at offset 4. A write-type instance of depth 16 reads 0x00000010. `out_valid` and `err_irq` are low, and `in_ready` is high.
- R2: Committed words leave on `out_data` in the order they were accepted. Words accepted since the last commit never raise `out_valid`.
- R3: A `rewind` pulse returns the write position to the last `mark`. Words accepted after the mark are discarded and are never read.
- R4: In a read-type instance, status bits [15:0] hold the number of committed unread words. Bit 31 is set when that number is 0. Bit 30 is set when it is exactly 1.
- R5: In a write-type instance, status bits [15:0] hold the free word count, counting uncommitted words as used. Bit 31 is set when that count is 0. Bit 30 is set when it is exactly 1.
- R6: `in_ready` is low while the memory is full, and a word offered then is not stored. `out_valid` is low while nothing is committed, and asserting `out_ready` then moves nothing.
- R7: When uncommitted words fill the whole memory, status bit 29 is set. `err_irq` rises one cycle later and stays high, even after a rewind, until a soft reset.
- R8: Writing 0x0000000A to offset 0 discards all data, rewinds all positions and clears `err_irq`. Writing any other value there has no effect.
- R9: A read at offset 0 returns the `ID_WORD` parameter. Status bits [28:16] always read as zero.
- R10: A `commit` also moves the mark to the commit point, so a later rewind never removes committed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Write word accepted this cycle |
| in_data | input | 32 | Write word |
| mark | input | 1 | Save the write position (after any write in the same cycle) |
| commit | input | 1 | Publish the words written so far to the reader |
| rewind | input | 1 | Return the write position to the mark; has priority over mark and commit |
| out_valid | output | 1 | Committed word available |
| out_ready | input | 1 | Reader takes the word |
| out_data | output | 32 | Read word |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| err_irq | output | 1 | Sticky deadlock interrupt |

## Verification
Most errors in the position logic show up at the ports within one or two cycles:
- A commit position that runs ahead of or behind the write position shows up at once in the status count.
- The same fault makes `out_valid` rise early or shows up as a wrong word on `out_data`.
- A rewind to the wrong place shows up when the packet that follows is drained and a discarded word reappears.
- A bad fullness calculation shows up as `in_ready` failing to drop on the sixteenth word, or as a missing deadlock flag.

Interrupt faults take longer to show. A non-sticky interrupt is caught only when it is sampled after a rewind. A soft reset that is too loose is caught only when a wrong key is written over stored data and the count is read back.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] CLR_KEY = 32'h0000_000A;
  localparam logic [2:0] OFS_ID   = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd4;
  typedef enum logic { KIND_READ = 1'b0, KIND_WRITE = 1'b1 } fifo_kind_e;
endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/pkt_fifo_ptrs.sv
module pkt_fifo_ptrs #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic          mark,
  input  logic          commit,
  input  logic          rewind,
  output logic [PW-1:0] wpos,
  output logic [PW-1:0] rpos,
  output logic [PW-1:0] used,
  output logic [PW-1:0] visible,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] mpos, cpos, wnext;

  assign wnext   = wpos + PW'(wr_fire);
  assign used    = wpos - rpos;
  assign visible = cpos - rpos;
  assign full    = (used == DEPTH_P);
  assign empty   = (cpos == rpos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos <= '0; rpos <= '0; mpos <= '0; cpos <= '0;
    end else if (clr) begin
      wpos <= '0; rpos <= '0; mpos <= '0; cpos <= '0;
    end else begin
      if (rd_fire) rpos <= rpos + PW'(1);
      if (rewind) begin
        wpos <= mpos;
      end else begin
        wpos <= wnext;
        if (mark || commit) mpos <= wnext;
        if (commit) cpos <= wnext;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_P) else $error("occupancy beyond depth"); // R6
  AST_COMMIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    visible <= used) else $error("commit point past write point"); // R2
  AST_REWIND_TO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !clr) |=> wpos == $past(mpos)) else $error("rewind target"); // R3
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !clr) |=> rpos == $past(rpos)) else $error("read while empty"); // R6
endmodule

// File: rtl/pkt_fifo_regs.sv
module pkt_fifo_regs
  import pkt_fifo_pkg::*;
#(
  parameter int          AW      = 4,
  parameter fifo_kind_e  KIND    = KIND_READ,
  parameter logic [31:0] ID_WORD = 32'h5046_4D52,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wen,
  input  logic [31:0]   reg_wdata,
  input  logic [PW-1:0] used,
  input  logic [PW-1:0] visible,
  input  logic          full,
  input  logic          empty,
  output logic          clr,
  output logic [31:0]   reg_rdata,
  output logic          err_irq
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic          dead, edge_flag, near_flag;
  logic [PW-1:0] cnt;
  logic [31:0]   stat;

  assign clr  = reg_wen && (reg_addr == OFS_ID) && (reg_wdata == CLR_KEY);
  assign dead = full && empty;

  generate
    if (KIND == KIND_WRITE) begin : g_wr
      assign cnt       = DEPTH_P - used;
      assign edge_flag = full;
    end else begin : g_rd
      assign cnt       = visible;
      assign edge_flag = empty;
    end
  endgenerate

  assign near_flag = (cnt == PW'(1));
  assign stat      = {edge_flag, near_flag, dead, 13'd0, 16'(cnt)};

  always_comb begin
    case (reg_addr)
      OFS_ID:   reg_rdata = ID_WORD;
      OFS_STAT: reg_rdata = stat;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_irq <= 1'b0;
    else if (clr)  err_irq <= 1'b0;
    else if (dead) err_irq <= 1'b1;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !clr) |=> err_irq) else $error("irq dropped"); // R7
  AST_IRQ_FOLLOWS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && !clr) |=> err_irq) else $error("irq missed"); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (used == '0) && !err_irq) else $error("soft reset"); // R8
endmodule

// File: rtl/pkt_fifo_mr.sv
module pkt_fifo_mr
  import pkt_fifo_pkg::*;
#(
  parameter int          AW      = 4,
  parameter fifo_kind_e  KIND    = KIND_READ,
  parameter logic [31:0] ID_WORD = 32'h5046_4D52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              mark,
  input  logic              commit,
  input  logic              rewind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err_irq
);
  localparam int PW = AW + 1;

  logic          clr, full, empty, wr_fire, rd_fire;
  logic [PW-1:0] wpos, rpos, used, visible;

  assign in_ready  = !full && !rewind;
  assign out_valid = !empty;
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = out_valid && out_ready;

  pkt_fifo_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .mark(mark), .commit(commit), .rewind(rewind), .wpos(wpos), .rpos(rpos),
    .used(used), .visible(visible), .full(full), .empty(empty)
  );

  pkt_fifo_mem #(.DW(WORD_W), .AW(AW)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wpos[AW-1:0]), .wdata(in_data),
    .raddr(rpos[AW-1:0]), .rdata(out_data)
  );

  pkt_fifo_regs #(.AW(AW), .KIND(KIND), .ID_WORD(ID_WORD)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .used(used), .visible(visible), .full(full),
    .empty(empty), .clr(clr), .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr && !rewind) |=> $stable(wpos)) else $error("write while full"); // R6
endmodule

// File: tb/sim_pkt_fifo_mr.sv
`timescale 1ns/100ps
module sim_pkt_fifo_mr;
  import pkt_fifo_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, mark = 0, commit = 0, rewind = 0, out_ready = 0, reg_wen = 0;
  logic [31:0] in_data = '0, reg_wdata = '0;
  logic [2:0]  reg_addr = 3'd4;
  logic        in_ready0, out_valid0, irq0, in_ready1, out_valid1, irq1;
  logic [31:0] out_data0, rdata0, out_data1, rdata1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_fifo_mr #(.AW(4), .KIND(KIND_READ), .ID_WORD(32'h5046_4D52)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready0), .in_data(in_data),
    .mark(mark), .commit(commit), .rewind(rewind), .out_valid(out_valid0), .out_ready(out_ready),
    .out_data(out_data0), .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(rdata0), .err_irq(irq0));

  pkt_fifo_mr #(.AW(4), .KIND(KIND_WRITE), .ID_WORD(32'h5046_4D52)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready1), .in_data(in_data),
    .mark(mark), .commit(commit), .rewind(rewind), .out_valid(out_valid1), .out_ready(out_ready),
    .out_data(out_data1), .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .err_irq(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stat check on both instances; called right after a negedge
  task automatic stat(input string tag, input logic [31:0] e0, input logic [31:0] e1);
    reg_addr = 3'd4; #1;
    chk({tag, " rd-type"}, rdata0, e0);
    chk({tag, " wr-type"}, rdata1, e1);
  endtask

  task automatic push(input logic [31:0] d, input bit cm, input bit mk);
    in_valid = 1; in_data = d; commit = cm; mark = mk;
    @(negedge clk);
    in_valid = 0; commit = 0; mark = 0;
  endtask

  task automatic pulse_commit(); commit = 1; @(negedge clk); commit = 0; endtask
  task automatic pulse_rewind(); rewind = 1; @(negedge clk); rewind = 0; endtask

  task automatic pop(input string tag, input logic [31:0] exp);
    #1;
    chk({tag, " valid"}, {31'd0, out_valid0}, 32'd1);
    chk({tag, " data"}, out_data0, exp);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic soft_clear(input logic [31:0] v);
    reg_addr = 3'd0; reg_wen = 1; reg_wdata = v;
    @(negedge clk);
    reg_wen = 0; reg_addr = 3'd4;
  endtask

  task automatic t_reset();
    stat("R1 reset status", 32'h8000_0000, 32'h0000_0010);
    chk("R1 out_valid", {31'd0, out_valid0}, 0);
    chk("R1 in_ready", {31'd0, in_ready0}, 1);
    chk("R1 irq", {31'd0, irq0}, 0);
    reg_addr = 3'd0; #1;
    chk("R9 id word", rdata0, 32'h5046_4D52);
    reg_addr = 3'd4;
  endtask

  task automatic t_hidden();
    push(32'hA1, 0, 1); push(32'hA2, 0, 0); push(32'hA3, 0, 0);
    #1; chk("R2 uncommitted hidden", {31'd0, out_valid0}, 0);
    stat("R4/R5 uncommitted counts", 32'h8000_0000, 32'h0000_000D);
    pulse_commit();
    stat("R4 committed count", 32'h0000_0003, 32'h0000_000D);
    pop("R2 word1", 32'hA1); pop("R2 word2", 32'hA2); pop("R2 word3", 32'hA3);
    stat("R4 drained", 32'h8000_0000, 32'h0000_0010);
  endtask

  task automatic t_almost();
    push(32'hB0, 1, 0);
    stat("R4 almost empty", 32'h4000_0001, 32'h0000_000F);
    pop("R2 single", 32'hB0);
  endtask

  task automatic t_rewind();
    push(32'hC1, 0, 0); push(32'hC2, 1, 0);
    push(32'hD1, 0, 0); push(32'hD2, 0, 0);
    stat("R5 before rewind", 32'h0000_0002, 32'h0000_000C);
    pulse_rewind();
    stat("R10 rewind keeps committed", 32'h0000_0002, 32'h0000_000E);
    push(32'hE1, 1, 0);
    pop("R3 keep1", 32'hC1); pop("R3 keep2", 32'hC2); pop("R3 new word", 32'hE1);
    #1; chk("R3 discarded gone", {31'd0, out_valid0}, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 15; i++) push(32'h100 + i, 1, 0);
    stat("R5 almost full", 32'h0000_000F, 32'h4000_0001);
    push(32'h10F, 1, 0);
    stat("R5 full", 32'h0000_0010, 32'h8000_0000);
    #1; chk("R6 in_ready low at full", {31'd0, in_ready0}, 0);
    push(32'hDEAD, 1, 0);
    stat("R6 full write ignored", 32'h0000_0010, 32'h8000_0000);
    for (int i = 0; i < 16; i++) pop("R6 drain", 32'h100 + i);
    out_ready = 1; @(negedge clk); out_ready = 0;
    stat("R6 empty read ignored", 32'h8000_0000, 32'h0000_0010);
    push(32'h77, 1, 0);
    pop("R6 next after empty read", 32'h77);
  endtask

  task automatic t_deadlock();
    for (int i = 0; i < 16; i++) push(32'h200 + i, 0, 0);
    stat("R7 deadlock status", 32'hA000_0000, 32'hA000_0000);
    chk("R7 irq not yet", {31'd0, irq0}, 0);
    @(negedge clk);
    chk("R7 irq raised", {31'd0, irq0}, 1);
    chk("R7 irq raised wr", {31'd0, irq1}, 1);
    pulse_rewind();
    stat("R7 after rewind", 32'h8000_0000, 32'h0000_0010);
    chk("R7 irq sticky", {31'd0, irq0}, 1);
  endtask

  task automatic t_soft();
    push(32'h31, 0, 0); push(32'h32, 1, 0);
    soft_clear(32'h0000_0005);
    stat("R8 wrong key ignored", 32'h0000_0002, 32'h0000_000E);
    chk("R8 irq kept by wrong key", {31'd0, irq0}, 1);
    soft_clear(32'h0000_000A);
    stat("R8 cleared", 32'h8000_0000, 32'h0000_0010);
    chk("R8 irq cleared", {31'd0, irq0}, 0);
    #1; chk("R8 nothing to read", {31'd0, out_valid0}, 0);
    push(32'h41, 1, 0);
    pop("R8 fresh data", 32'h41);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hidden();
    t_almost();
    t_rewind();
    t_full();
    t_deadlock();
    t_soft();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule